// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block turns one parallel byte into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bit times. All timing comes from an enable pulse, `tick16`, that the surrounding logic raises sixteen times per bit period. The block counts these pulses rather than clock cycles.

A byte is presented with a one-cycle load strobe. If the serializer is idle, the frame starts on the next clock. If a frame is already in flight, the byte waits in a one-entry holding register. It goes out directly after the current stop period, with no idle gap. The format inputs (length, parity, stop select) are read at the moment a frame begins. A break input pulls the line low for as long as it is held.

Top module: `async_char_tx`

## Requirements
- R1: After reset and between frames the line `txd` is high, `busy` is 0 and `tx_empty` is 1.
- R2: A byte loaded while the block is idle starts its frame on the clock after the load. The frame opens with a start bit that is low for 16 ticks.
- R3: The data bits follow the start bit, least significant bit first, each lasting 16 ticks. Their number is 5 + `wlen`, where `wlen` codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits.
- R4: With `par_en`=1, one parity bit lasting 16 ticks follows the data bits. With `par_even`=1 the count of ones over the sent data bits and the parity bit is even. With `par_even`=0 that count is odd.
- R5: With `par_en`=0 no parity bit is sent. Data bits above the selected length are never sent and have no effect on parity.
- R6: The stop period is high. Its length is 16 ticks when `stop_long`=0, 24 ticks when `stop_long`=1 with 5-bit characters, and 32 ticks when `stop_long`=1 with any other length.
- R7: Clock cycles without `tick16` do not advance the frame. With ticks every third cycle, a frame lasts three times as many clocks as it has ticks.
- R8: `tx_empty` is low whenever a byte is pending or a frame is in progress. A byte loaded while `busy` is held and its start bit follows the previous stop period with no idle gap.
- R9: While `brk` is 1, `txd` is 0. Break does not disturb frame timing: once it is released, the line shows what the frame would have shown at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| load | input | 1 | One-cycle strobe that accepts `load_data` |
| load_data | input | 8 | Byte to transmit |
| wlen | input | 2 | Character length code (data bits = 5 + code) |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop_long | input | 1 | 0 = one stop bit, 1 = one and a half (5-bit characters) or two stop bits |
| brk | input | 1 | Forces the line low while set |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is being shifted out |
| tx_empty | output | 1 | No byte pending and shifter idle |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and 16 ticks per bit. These are small enough that every combination of character length, parity mode and stop select can be swept against several data patterns. Each frame is compared tick by tick against a waveform the bench computes arithmetically. Running the tick on every clock makes each tick visible as one sampled cycle. Slowing the tick to every third cycle, and stopping it altogether, brings the tick-counted timing within reach. A second byte loaded mid-frame, and a break window inside a frame, cover the holding register and the line override.

// File: rtl/async_char_tx_pkg.sv
`timescale 1ns/1ps
package async_char_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/tx_hold_reg.sv
`timescale 1ns/1ps
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              take,
    output logic              pend,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load) begin
            h_d.full = 1'b1;
            h_d.data = din;
        end else if (take) begin
            h_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign pend = h_q.full;
    assign dout = h_q.data;

    // R8
    pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.full && !load && !take) |=> h_q.full);
endmodule

// File: rtl/tx_parity.sv
`timescale 1ns/1ps
module tx_parity #(
    parameter int DATA_W = 8,
    parameter int MIN_W  = 5
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        wlen,
    output logic              xor_out
);
    logic [DATA_W-1:0] mask;

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (g < MIN_W) ? 1'b1 : (g < MIN_W + int'(wlen));
    end

    assign xor_out = ^(data & mask);
endmodule

// File: rtl/tx_frame_engine.sv
`timescale 1ns/1ps
module tx_frame_engine
    import async_char_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16,
    parameter int MIN_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pend,
    input  logic [DATA_W-1:0] pdata,
    input  logic              pxor,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              stop_long,
    output logic              take,
    output logic              ser_bit,
    output logic              busy
);
    localparam int CNT_W = $clog2(2 * OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] STOP1_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] STOPH_LAST = CNT_W'((3 * OVERSAMPLE) / 2 - 1);
    localparam logic [CNT_W-1:0] STOP2_LAST = CNT_W'(2 * OVERSAMPLE - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  nbits;
        logic              par_on;
        logic              par_bit;
        logic [CNT_W-1:0]  stop_last;
    } eng_t;

    eng_t r_d, r_q;
    logic bit_done;
    logic start_ok;

    always_comb begin
        r_d      = r_q;
        take     = 1'b0;
        start_ok = 1'b0;
        bit_done = tick && (r_q.cnt == ((r_q.state == ST_STOP) ? r_q.stop_last : BIT_LAST));
        if (tick && r_q.state != ST_IDLE) r_d.cnt = r_q.cnt + 1'b1;
        case (r_q.state)
            ST_IDLE:  start_ok = pend;
            ST_START: if (bit_done) begin
                r_d.state = ST_DATA;
                r_d.cnt   = '0;
                r_d.idx   = '0;
            end
            ST_DATA:  if (bit_done) begin
                r_d.cnt = '0;
                r_d.sh  = r_q.sh >> 1;
                if (r_q.idx == r_q.nbits - 1'b1) r_d.state = r_q.par_on ? ST_PAR : ST_STOP;
                else                             r_d.idx   = r_q.idx + 1'b1;
            end
            ST_PAR:   if (bit_done) begin
                r_d.state = ST_STOP;
                r_d.cnt   = '0;
            end
            ST_STOP:  if (bit_done) begin
                r_d.cnt = '0;
                if (pend) start_ok  = 1'b1;
                else      r_d.state = ST_IDLE;
            end
            default:  r_d.state = ST_IDLE;
        endcase
        if (start_ok) begin
            take          = 1'b1;
            r_d.state     = ST_START;
            r_d.cnt       = '0;
            r_d.sh        = pdata;
            r_d.nbits     = IDX_W'(MIN_W) + IDX_W'(wlen);
            r_d.par_on    = par_en;
            r_d.par_bit   = par_even ? pxor : ~pxor;
            if (!stop_long)       r_d.stop_last = STOP1_LAST;
            else if (wlen == 2'd0) r_d.stop_last = STOPH_LAST;
            else                  r_d.stop_last = STOP2_LAST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.state)
            ST_START: ser_bit = 1'b0;
            ST_DATA:  ser_bit = r_q.sh[0];
            ST_PAR:   ser_bit = r_q.par_bit;
            default:  ser_bit = 1'b1;
        endcase
    end

    assign busy = (r_q.state != ST_IDLE);

    // R7
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && r_q.state != ST_IDLE) |=> ($stable(r_q.state) && $stable(r_q.cnt)));
    // R6
    stop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STOP) |-> (r_q.cnt <= r_q.stop_last));
    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DATA) |-> (r_q.idx < r_q.nbits));
    // R2
    start_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pend));
endmodule

// File: rtl/async_char_tx.sv
`timescale 1ns/1ps
module async_char_tx #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              stop_long,
    input  logic              brk,
    output logic              txd,
    output logic              busy,
    output logic              tx_empty
);
    localparam int MIN_W = 5;

    logic              pend;
    logic              take;
    logic [DATA_W-1:0] pdata;
    logic              pxor;
    logic              ser_bit;

    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(load), .din(load_data),
        .take(take), .pend(pend), .dout(pdata)
    );

    tx_parity #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_par (
        .data(pdata), .wlen(wlen), .xor_out(pxor)
    );

    tx_frame_engine #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .MIN_W(MIN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .pend(pend), .pdata(pdata),
        .pxor(pxor), .wlen(wlen), .par_en(par_en), .par_even(par_even),
        .stop_long(stop_long), .take(take), .ser_bit(ser_bit), .busy(busy)
    );

    assign txd      = ser_bit & ~brk;
    assign tx_empty = ~pend & ~busy;

    // R8
    empty_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> !busy);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk) |-> txd);
endmodule

// File: tb/async_char_tx_tb_top.sv
`timescale 1ns/1ps
module async_char_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic [1:0] wlen = 2'd0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       stop_long = 1'b0;
    logic       brk = 1'b0;
    logic       txd, busy, tx_empty;

    int checks = 0;
    int fails  = 0;
    int tick_div = 1;
    int tphase = 0;
    bit done = 0;

    always #2 clk = ~clk;

    async_char_tx dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .load(load), .load_data(load_data),
        .wlen(wlen), .par_en(par_en), .par_even(par_even), .stop_long(stop_long),
        .brk(brk), .txd(txd), .busy(busy), .tx_empty(tx_empty)
    );

    initial forever begin
        @(negedge clk);
        if (tick_div == 0) tick16 <= 1'b0;
        else if (tick_div == 1) tick16 <= 1'b1;
        else begin
            tick16 <= (tphase == 0);
            tphase = (tphase + 1) % tick_div;
        end
    end

    function automatic int nbits_of(int wl);
        return 5 + wl;
    endfunction

    function automatic int frame_len(int wl, int pe, int sl);
        int n = nbits_of(wl);
        int st = (sl == 0) ? 16 : ((n == 5) ? 24 : 32);
        return 16 * (1 + n + pe) + st;
    endfunction

    function automatic logic exp_bit(logic [7:0] d, int wl, int pe, int ev, int k);
        int n = nbits_of(wl);
        int slot = k / 16;
        logic x = 1'b0;
        if (slot == 0) return 1'b0;
        if (slot - 1 < n) return d[slot - 1];
        if (pe != 0 && slot - 1 == n) begin
            for (int i = 0; i < n; i++) x = x ^ d[i];
            return (ev != 0) ? x : ~x;
        end
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int wl, input int pe, input int ev, input int sl);
        wlen = 2'(wl); par_en = pe[0]; par_even = ev[0]; stop_long = sl[0];
    endtask

    // Checks one frame tick by tick starting at the current negedge (tick on every clock).
    task automatic check_frame(input logic [7:0] d, input int wl, input int pe, input int ev,
                               input int sl, input int bf, input int bt, input string req);
        int L = frame_len(wl, pe, sl);
        int bad = 0, fa = 0, fe = 0;
        for (int k = 0; k < L; k++) begin
            logic e;
            brk = (k >= bf && k < bt);
            #1;
            e = (k >= bf && k < bt) ? 1'b0 : exp_bit(d, wl, pe, ev, k);
            if (txd !== e || busy !== 1'b1) begin
                if (bad == 0) begin fa = k * 2 + txd; fe = k * 2 + e; end
                bad++;
            end
            @(negedge clk);
        end
        brk = 1'b0;
        check(bad == 0, req, fa, fe);
    endtask

    task automatic start_load(input logic [7:0] d);
        load_data = d; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        #1;
        check(txd === 1'b1 && busy === 1'b0 && tx_empty === 1'b1, req,
              {txd, busy, tx_empty}, 3'b101);
    endtask

    initial begin
        logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'hE0, 8'h5B};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset");

        // R2 R3 R4 R5 R6: sweep of every format against several bytes
        for (int wl = 0; wl < 4; wl++)
            for (int pm = 0; pm < 3; pm++)
                for (int sl = 0; sl < 2; sl++)
                    for (int p = 0; p < 4; p++) begin
                        int pe = (pm != 0) ? 1 : 0;
                        int ev = (pm == 1) ? 1 : 0;
                        set_cfg(wl, pe, ev, sl);
                        start_load(pats[p]);
                        check_frame(pats[p], wl, pe, ev, sl, -1, -1, "R2/R3/R4/R5/R6 frame");
                        check_idle("R1 between frames");
                    end

        // R8: second byte loaded mid-frame, sent with no idle gap
        set_cfg(3, 1, 0, 0);
        start_load(8'h96);
        for (int k = 0; k < 20; k++) @(negedge clk);
        load_data = 8'h2D; load = 1'b1;
        #1;
        check(tx_empty === 1'b0, "R8 empty low while busy", tx_empty, 0);
        @(negedge clk);
        load = 1'b0;
        #1;
        check(tx_empty === 1'b0 && busy === 1'b1, "R8 pending byte", {tx_empty, busy}, 2'b01);
        begin
            int L = frame_len(3, 1, 0);
            int bad = 0;
            for (int k = 21; k < L; k++) begin
                #1;
                if (txd !== exp_bit(8'h96, 3, 1, 0, k) || tx_empty !== 1'b0) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R8 first frame with byte held", bad, 0);
        end
        check_frame(8'h2D, 3, 1, 0, 0, -1, -1, "R8 held byte follows without gap");
        check_idle("R1 after back-to-back");

        // R9: break window inside a frame, timing preserved
        set_cfg(1, 1, 1, 1);
        start_load(8'h4E);
        check_frame(8'h4E, 1, 1, 1, 1, 30, 70, "R9 break forces low");
        check_idle("R1 after break");
        brk = 1'b1;
        #1;
        check(txd === 1'b0, "R9 break while idle", txd, 0);
        @(negedge clk);
        brk = 1'b0;

        // R7: tick every third cycle
        tick_div = 3;
        set_cfg(0, 0, 0, 0);
        start_load(8'h11);
        begin
            int cyc = 0;
            int L = frame_len(0, 0, 0);
            while (busy === 1'b1 && cyc < 5000) begin @(negedge clk); cyc++; end
            check(cyc >= 3 * L - 3 && cyc <= 3 * L + 3, "R7 slow tick duration", cyc, 3 * L);
        end

        // R7: no ticks at all, frame stays in its start bit
        tick_div = 0;
        set_cfg(2, 0, 0, 0);
        start_load(8'hFF);
        repeat (100) @(negedge clk);
        #1;
        check(busy === 1'b1 && txd === 1'b0, "R7 frozen without tick", {busy, txd}, 2'b10);
        tick_div = 1;
        begin
            int cyc = 0;
            while (busy === 1'b1 && cyc < 5000) begin @(negedge clk); cyc++; end
            check(cyc >= frame_len(2, 0, 0) - 2 && cyc <= frame_len(2, 0, 0) + 2,
                  "R7 resumes after ticks return", cyc, frame_len(2, 0, 0));
        end
        check_idle("R1 final");

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule